// File: doc/BRIEF.md
# Accumulative Hash Final-Padding Detector

This block sits beside a hash engine that receives one message as a series of buffer requests. It keeps a running byte total over the requests of the message. When a request ends, the block inspects the request's last eight bytes and, if needed, one byte inside the buffer. From these it decides whether the request carries the final message padding. The end of the message is found from the data alone, not from any end-of-list flag.

The bytes are read through a one-byte port into the request buffer. When padding is confirmed, the block reports where the padding starts, which is the length of data to feed the hash core. It also reports the true message length, then clears its running total and its count of cached chunks. A request without padding is counted as a cached data chunk.

A scatter-gather request is always checked. A direct request is checked only while chunks are cached; otherwise it passes through unchanged.

The controller has four states:
- IDLE waits for a request. On accept it goes to SCAN.
- SCAN evaluates the length rule. It goes to PROBE when a marker read is needed, and to DONE otherwise.
- PROBE compares the fetched byte and goes to DONE.
- DONE reports for one cycle, commits the accumulator update and goes back to IDLE.

Top module: `pad_detector`

## Requirements
- R1: After reset, `busy`, `res_valid`, `rd_en`, `acc_total` and `acc_chunks` are all zero.
- R2: A request is accepted only in IDLE. It is checked when `req_sg` is 1 or `acc_chunks` is nonzero, and a checked request adds `req_len` to `acc_total` (modulo 2^LEN_W). An unchecked request (direct, no cached chunks) leaves `acc_total` and `acc_chunks` unchanged, reports `res_pad`=0 and `res_cut_len`=`req_len`, and issues no read.
- R3: `req_tail` holds the last 8 request bytes in big-endian order: bits [63:56] are the byte at offset `req_len`-8 and bits [7:0] are the byte at `req_len`-1. `res_msg_len` is the bit count divided by 8, which is `req_tail[LEN_W+2:3]`; bits [2:0] are ignored.
- R4: Let T be the updated total and M the message length, with pad size P = T - M. A checked request is a padding candidate only if M <= T and 1 <= P <= `req_len`. The padding offset is `req_len` - P.
- R5: For a candidate, exactly one read is issued at the padding offset. Padding is confirmed only if the returned byte equals 0x80.
- R6: When padding is confirmed, `res_pad`=1 and `res_cut_len` is the padding offset. After the report, `acc_total` and `acc_chunks` are zero.
- R7: A scatter-gather request without padding reports `res_cut_len`=`req_len` and keeps the updated total. `acc_chunks` increases by one, saturating at MAX_CHUNKS.
- R8: A checked direct request without padding keeps the updated total and leaves `acc_chunks` unchanged.
- R9: `res_valid` is a one-cycle pulse. Counting negative edges from the one where the request was driven, it is seen 2 edges later when no read is issued and 3 edges later when a read is issued.
- R10: `req_valid` is ignored while `busy` is 1, including the DONE cycle.
- R11: No read is issued for a request that is not a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request completed, sampled in IDLE |
| req_sg | input | 1 | 1 = scatter-gather request, 0 = direct request |
| req_len | input | LEN_W | Request length in bytes |
| req_tail | input | 64 | Last 8 bytes of the request, big-endian |
| rd_en | output | 1 | Byte read strobe into the request buffer |
| rd_addr | output | LEN_W | Byte offset of the read |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| busy | output | 1 | A request is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_pad | output | 1 | Final padding found |
| res_cut_len | output | LEN_W | Effective data length (padding offset when found) |
| res_msg_len | output | LEN_W | Message length decoded from the tail |
| acc_total | output | LEN_W | Running byte total |
| acc_chunks | output | CNT_W | Cached chunk count |

## Verification
A new request can arrive in the same cycle as the DONE commit, which clears the accumulator or counts a chunk. It can also arrive at the first SCAN cycle, when the total has just been increased. The bench provokes both by holding `req_valid` high, with a different length, from the cycle after acceptance through the DONE pulse. It then judges the result by comparing `acc_total` and `acc_chunks` with a model that counts only the first request. Random sequences of cached chunks ending in direct or scatter-gather final requests are mixed with directed cases: zero pad size, pad size above the request length, a wrong marker byte and chunk saturation.

// File: rtl/pad_det_pkg.sv
package pad_det_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PROBE,
        ST_DONE
    } det_state_e;

    localparam logic [7:0] PAD_MARK = 8'h80;

endpackage

// File: rtl/pad_len_eval.sv
// Length rule: decides whether a request may hold the final padding
// and where that padding would start.
module pad_len_eval #(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0] run_total,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] msg_len,
    output logic             cand,
    output logic [LEN_W-1:0] pad_off
);

    logic [LEN_W-1:0] pad_sz;

    always_comb begin
        pad_sz  = run_total - msg_len;
        cand    = (msg_len <= run_total) && (pad_sz != '0) && (pad_sz <= req_len);
        pad_off = req_len - pad_sz;
    end

endmodule

// File: rtl/pad_acc_store.sv
// Running byte total and cached chunk counter.
module pad_acc_store #(
    parameter  int LEN_W      = 32,
    parameter  int MAX_CHUNKS = 16,
    localparam int CNT_W      = $clog2(MAX_CHUNKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    input  logic             commit_en,
    input  logic             commit_pad,
    input  logic             commit_chunk,
    output logic [LEN_W-1:0] total,
    output logic [CNT_W-1:0] chunks
);

    localparam logic [CNT_W-1:0] CHUNK_CAP = CNT_W'(MAX_CHUNKS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total  <= '0;
            chunks <= '0;
        end else if (add_en) begin
            total <= total + add_len;
        end else if (commit_en) begin
            if (commit_pad) begin
                total  <= '0;
                chunks <= '0;
            end else if (commit_chunk && (chunks < CHUNK_CAP)) begin
                chunks <= chunks + 1'b1;
            end
        end
    end

    // R7: the chunk count never passes its cap
    p_chunk_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chunks <= CHUNK_CAP);

    // R6: a padded commit leaves an empty accumulator
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && commit_pad) |=> (total == '0 && chunks == '0));

    // R2: accept and commit are never in the same cycle
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_en && commit_en));

    // R8: with no add and no commit, the total holds
    p_total_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !commit_en) |=> $stable(total));

endmodule

// File: rtl/pad_detector.sv
module pad_detector
    import pad_det_pkg::*;
#(
    parameter  int LEN_W      = 32,
    parameter  int MAX_CHUNKS = 16,
    localparam int CNT_W      = $clog2(MAX_CHUNKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sg,
    input  logic [LEN_W-1:0] req_len,
    input  logic [63:0]      req_tail,
    output logic             rd_en,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             busy,
    output logic             res_valid,
    output logic             res_pad,
    output logic [LEN_W-1:0] res_cut_len,
    output logic [LEN_W-1:0] res_msg_len,
    output logic [LEN_W-1:0] acc_total,
    output logic [CNT_W-1:0] acc_chunks
);

    det_state_e       state_q, state_d;
    logic             sg_q, chk_q, pad_q;
    logic [LEN_W-1:0] len_q, msg_q, cut_q;
    logic             cand, probe_go, accept, chk_now;
    logic             add_en, commit_en, commit_chunk;
    logic [LEN_W-1:0] pad_off;
    logic             unused_tail;

    assign unused_tail = ^{req_tail[63:LEN_W+3], req_tail[2:0]};

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign chk_now  = req_sg || (acc_chunks != '0);
    assign add_en   = accept && chk_now;
    assign probe_go = chk_q && cand;

    pad_len_eval #(.LEN_W(LEN_W)) eval_i (
        .run_total (acc_total),
        .req_len   (len_q),
        .msg_len   (msg_q),
        .cand      (cand),
        .pad_off   (pad_off)
    );

    pad_acc_store #(.LEN_W(LEN_W), .MAX_CHUNKS(MAX_CHUNKS)) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .add_en       (add_en),
        .add_len      (req_len),
        .commit_en    (commit_en),
        .commit_pad   (pad_q),
        .commit_chunk (commit_chunk),
        .total        (acc_total),
        .chunks       (acc_chunks)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SCAN;
            ST_SCAN:  state_d = probe_go ? ST_PROBE : ST_DONE;
            ST_PROBE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        rd_en        = (state_q == ST_SCAN) && probe_go;
        rd_addr      = pad_off;
        res_valid    = (state_q == ST_DONE);
        commit_en    = (state_q == ST_DONE);
        commit_chunk = sg_q && !pad_q;
        res_pad      = pad_q;
        res_cut_len  = cut_q;
        res_msg_len  = msg_q;
    end

    // request latch and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sg_q  <= 1'b0;
            chk_q <= 1'b0;
            pad_q <= 1'b0;
            len_q <= '0;
            msg_q <= '0;
            cut_q <= '0;
        end else if (accept) begin
            sg_q  <= req_sg;
            chk_q <= chk_now;
            pad_q <= 1'b0;
            len_q <= req_len;
            msg_q <= req_tail[LEN_W+2:3];
            cut_q <= req_len;
        end else if (state_q == ST_PROBE && rd_data == PAD_MARK) begin
            pad_q <= 1'b1;
            cut_q <= pad_off;
        end
    end

    // R9: result strobe lasts one cycle
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4: a read stays inside the request buffer
    p_rd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr < len_q));

    // R5: a single read per request
    p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R6: a confirmed cut lies inside the request
    p_cut_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pad) |-> (res_cut_len < len_q));

    // R10: busy is not dropped before the result strobe
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_valid) |=> busy);

endmodule

// File: tb/pad_detector_tb_top.sv
module pad_detector_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 32;
    localparam int MAXC       = 16;
    localparam int CNT_W      = $clog2(MAXC + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_sg = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic [63:0]      req_tail = '0;
    logic             rd_en;
    logic [LEN_W-1:0] rd_addr;
    logic [7:0]       rd_data = '0;
    logic             busy, res_valid, res_pad;
    logic [LEN_W-1:0] res_cut_len, res_msg_len, acc_total;
    logic [CNT_W-1:0] acc_chunks;

    int tests = 0;
    int fails = 0;
    int rd_count = 0;
    logic [31:0] m_total = '0;
    int          m_chunks = 0;
    logic [7:0]  mem [256];

    pad_detector #(.LEN_W(LEN_W), .MAX_CHUNKS(MAXC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sg(req_sg),
        .req_len(req_len), .req_tail(req_tail), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .res_valid(res_valid), .res_pad(res_pad),
        .res_cut_len(res_cut_len), .res_msg_len(res_msg_len),
        .acc_total(acc_total), .acc_chunks(acc_chunks)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data  <= mem[rd_addr[7:0]];
            rd_count <= rd_count + 1;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    endtask

    function automatic logic [63:0] mk_tail(input logic [31:0] msg, input logic [2:0] low);
        return {29'd0, msg, low};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_total = '0;
        m_chunks = 0;
        @(negedge clk);
        check("R1 busy", 64'(busy), 0);
        check("R1 res_valid", 64'(res_valid), 0);
        check("R1 rd_en", 64'(rd_en), 0);
        check("R1 acc_total", 64'(acc_total), 0);
        check("R1 acc_chunks", 64'(acc_chunks), 0);
    endtask

    task automatic run_req(input bit sg, input logic [31:0] len, input logic [63:0] tail, input bit spam);
        bit          chk, cand, pad;
        logic [31:0] t, msg, ps, off, cut;
        int          lat, r0, k;
        chk  = sg || (m_chunks != 0);
        t    = chk ? m_total + len : m_total;
        msg  = tail[34:3];
        ps   = t - msg;
        cand = chk && (msg <= t) && (ps != 0) && (ps <= len);
        off  = len - ps;
        pad  = cand && (mem[off[7:0]] == 8'h80);
        cut  = pad ? off : len;
        lat  = cand ? 3 : 2;
        if (pad) begin
            m_total = '0;
            m_chunks = 0;
        end else if (chk) begin
            m_total = t;
            if (sg && m_chunks < MAXC) m_chunks++;
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_sg    = sg;
        req_len   = len;
        req_tail  = tail;
        r0 = rd_count;
        @(negedge clk);
        k = 1;
        if (spam) req_len = len + 32'd7;
        else      req_valid = 1'b0;
        while (!res_valid && k < 10) begin
            @(negedge clk);
            k++;
        end
        req_valid = 1'b0;
        check("R9 latency", 64'(k), 64'(lat));
        check("R5 R6 res_pad", 64'(res_pad), 64'(pad));
        check("R4 R6 R7 res_cut_len", 64'(res_cut_len), 64'(cut));
        check("R3 res_msg_len", 64'(res_msg_len), 64'(msg));
        @(negedge clk);
        check("R9 pulse width", 64'(res_valid), 0);
        check("R2 R6 R8 R10 acc_total", 64'(acc_total), 64'(m_total));
        check("R6 R7 R8 acc_chunks", 64'(acc_chunks), 64'(m_chunks));
        check("R5 R11 read count", 64'(rd_count - r0), cand ? 64'd1 : 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, p, len, msg;
        bit          sg;
        void'($urandom(32'd4242));
        fill_mem();
        do_reset();

        // R2: direct request with nothing cached passes through
        run_req(1'b0, 32'd20, mk_tail(32'd5, 3'd0), 1'b0);
        // R4 R5 R6: single scatter-gather request carrying padding
        fill_mem(); mem[20] = 8'h80;
        run_req(1'b1, 32'd64, mk_tail(32'd20, 3'd0), 1'b0);
        // R7: data chunk, then direct final request with padding
        fill_mem();
        run_req(1'b1, 32'd30, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        fill_mem(); mem[10] = 8'h80;
        run_req(1'b0, 32'd40, mk_tail(32'd40, 3'd5), 1'b0);
        // R5: wrong marker byte, then R8 direct without padding
        fill_mem(); mem[8] = 8'h81;
        run_req(1'b1, 32'd32, mk_tail(32'd8, 3'd0), 1'b0);
        fill_mem();
        run_req(1'b0, 32'd16, mk_tail(32'd900, 3'd0), 1'b0);
        // R11: pad size zero, no read
        run_req(1'b1, 32'd12, mk_tail(m_total + 32'd12, 3'd0), 1'b0);
        // R11: pad size larger than request, no read
        run_req(1'b1, 32'd16, mk_tail(m_total - 32'd4, 3'd0), 1'b0);
        // R7: chunk count saturation
        do_reset();
        for (int i = 0; i < MAXC + 2; i++) begin
            fill_mem();
            run_req(1'b1, 32'd10, 64'hFFFF_FFFF_0000_0000, 1'b0);
        end
        // R10: request held high during busy is ignored
        do_reset();
        fill_mem(); mem[4] = 8'h80;
        run_req(1'b1, 32'd24, mk_tail(32'd4, 3'd0), 1'b1);
        fill_mem();
        run_req(1'b1, 32'd24, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        // R1: reset mid-message
        do_reset();

        // random sequences
        for (int s = 0; s < 60; s++) begin
            int nch;
            nch = int'($urandom % 4);
            for (int c = 0; c < nch; c++) begin
                fill_mem();
                run_req(1'b1, 32'd1 + ($urandom % 60), {$urandom, $urandom}, ($urandom % 5) == 0);
            end
            fill_mem();
            d   = $urandom % 40;
            p   = 32'd9 + ($urandom % 60);
            len = d + p;
            sg  = 1'($urandom % 2);
            msg = m_total + d;
            if (($urandom % 6) != 0) mem[d[7:0]] = 8'h80;
            if (($urandom % 8) == 0) msg = msg + ($urandom % 5);
            run_req(sg, len, mk_tail(msg, 3'($urandom)), ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule